// File: doc/BRIEF.md
# Codec Sample Transfer Status Controller

This block sits between a host register port and a stereo sample path. On every sample tick it moves one captured sample into a one-entry capture slot for the host to collect. It also sends one host-supplied playback sample, or a midscale fill value, to the playback output. Two faults are recorded: a capture overrun, when a new sample meets an uncollected one, and a playback underrun, when the tick finds no host sample. The per-channel range codes from the input path are latched into the same read-only status register at each tick.

Two 16-bit transfer counters, one for playback and one for capture, count completed transfers against programmable base values. When a counter reaches its base it raises a sticky interrupt request and starts over. The request reaches the `irq` pin only while the pin-enable bit is set. In legacy mode the capture counter uses the playback base, so a single base value serves both directions. The live counter values cannot be read.

The capture slot is a two-state machine. In EMPTY, a tick loads the sample and moves to FULL. In FULL, a pop alone returns to EMPTY, a tick with a pop reloads and stays in FULL, and a tick without a pop is an overrun that stays in FULL. The playback slot is also a two-state machine. In EMPTY, a push moves to LOADED; a tick plays midscale and is an underrun. In LOADED, a tick plays the held sample and returns to EMPTY.

Top module: `smp_xfer_ctl`

## Requirements
- R1: While reset is held, all register reads (addresses 0 to 5) return 00h, `irq` and `cap_valid` are low, `pb_ready` is high and `err_sum` is low.
- R2: A tick with the capture slot empty stores `cap_in`, which then appears on `cap_data` with `cap_valid` high. That tick clears status bit 7.
- R3: A tick with the capture slot full and no pop keeps the stored sample, drops the new one, and sets status bit 7 (capture overrun).
- R4: A tick with a playback sample loaded drives that sample on `pb_out` and clears status bit 6. A tick with none loaded drives midscale and sets status bit 6 (playback underrun). Midscale is 0000h when `fmt16`=1 and 0080h when `fmt16`=0.
- R5: `err_sum` equals status bit 7 OR status bit 6.
- R6: At each tick, status bits [3:2] take `rng_right` and bits [1:0] take `rng_left`. Code 0 means below -1 dB, 1 means -1 to 0 dB, 2 means 0 to +1 dB, and 3 means above +1 dB.
- R7: Status bit 5 reads 1 when `cal_busy` is low. Status bit 4 reads the OR of `pb_req` and `cap_req`. Both follow their inputs one clock later. Writes to address 1 have no effect.
- R8: Address 2 and 3 hold the upper and lower bytes of the playback base. Address 4 and 5 hold the upper and lower bytes of the capture base. Reads return the value last written.
- R9: Address 0 bit 1 enables the interrupt pin; the other bits of address 0 read 0. A counter reaching its base sets the request, and `irq` = request AND enable. The request stays set until `irq_clr` is pulsed; a new terminal count in the same cycle as the clear wins.
- R10: After a terminal count, the counter restarts from zero, so the next request follows another base-count transfers. Writing either byte of a base restarts that counter.
- R11: With `legacy_mode`=1, the capture counter counts against the playback base, and a playback base write also restarts it.
- R12: A push while a playback sample is loaded is ignored. A pop with the capture slot empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| irq_clr | input | 1 | Clears the interrupt request |
| legacy_mode | input | 1 | Shared base value for both directions |
| fmt16 | input | 1 | Playback format: 1 = signed 16-bit, 0 = unsigned 8-bit |
| smp_tick | input | 1 | One-cycle sample tick |
| cap_in | input | 16 | Sample from the input path |
| rng_left | input | 2 | Left range code from the input path |
| rng_right | input | 2 | Right range code from the input path |
| cap_pop | input | 1 | Host collects the capture sample |
| cap_data | output | 16 | Stored capture sample |
| cap_valid | output | 1 | Capture slot full |
| pb_push | input | 1 | Host offers a playback sample |
| pb_in | input | 16 | Playback sample from the host |
| pb_ready | output | 1 | Playback slot empty |
| pb_out | output | 16 | Sample sent to the output path |
| pb_req | input | 1 | Playback request level |
| cap_req | input | 1 | Capture request level |
| cal_busy | input | 1 | Calibration in progress |
| err_sum | output | 1 | Overrun or underrun summary |
| irq | output | 1 | Active-high interrupt |

## Verification
If a slot holds the wrong state, the error shows at the next tick. The wrong sample or fill value appears on `pb_out` or `cap_data`, and a wrong overrun or underrun bit appears in the status register, one clock after that tick. A counter that is off by one, or that fails to restart, shows up as `irq` rising one transfer early or late at its next terminal count. The bench therefore counts transfers exactly across several rounds. It also checks the shared-base mode, where the playback and capture bases differ so that a wrong selection changes when `irq` rises.

// File: rtl/smp_xfer_pkg.sv
package smp_xfer_pkg;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 8;
    localparam int NDIR   = 2;              // 0 = playback, 1 = capture

    localparam logic [ADDR_W-1:0] A_PIN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ERR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_BASE = 3'd2;  // hi/lo pairs follow per direction

    localparam int PIN_EN_BIT = 1;
    localparam int ST_OVR     = 7;
    localparam int ST_UNF     = 6;
    localparam int ST_CAL     = 5;
    localparam int ST_REQ     = 4;

    typedef enum logic {CAP_EMPTY = 1'b0, CAP_FULL = 1'b1} cap_state_t;
    typedef enum logic {PB_EMPTY = 1'b0, PB_LOADED = 1'b1} pb_state_t;
endpackage

// File: rtl/cap_slot.sv
module cap_slot
    import smp_xfer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid,
    output logic              xfer,
    output logic              ovr
);
    cap_state_t        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        xfer    = 1'b0;
        ovr     = 1'b0;
        unique case (state_q)
            CAP_EMPTY: begin
                if (tick) begin
                    xfer    = 1'b1;
                    state_d = CAP_FULL;
                end
            end
            CAP_FULL: begin
                if (tick && pop)      xfer    = 1'b1;
                else if (tick)        ovr     = 1'b1;
                else if (pop)         state_d = CAP_EMPTY;
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (xfer) data_q <= din;
    end

    assign dout  = data_q;
    assign valid = (state_q == CAP_FULL);

    p_keep_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_FULL && tick && !pop) |=> (valid && $stable(dout)));
    p_load_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_EMPTY && tick) |=> (valid && dout == $past(din)));
endmodule

// File: rtl/pb_slot.sv
module pb_slot
    import smp_xfer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              fmt16,
    output logic [DATA_W-1:0] dout,
    output logic              ready,
    output logic              xfer,
    output logic              unf
);
    localparam logic [DATA_W-1:0] MID8  = DATA_W'(1) << 7;
    localparam logic [DATA_W-1:0] MID16 = '0;

    pb_state_t         state_q, state_d;
    logic [DATA_W-1:0] hold_q, out_q;
    logic              load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        xfer    = 1'b0;
        unf     = 1'b0;
        unique case (state_q)
            PB_EMPTY: begin
                unf = tick;
                if (push) begin
                    load    = 1'b1;
                    state_d = PB_LOADED;
                end
            end
            PB_LOADED: begin
                if (tick) begin
                    xfer    = 1'b1;
                    state_d = PB_EMPTY;
                end
            end
            default: state_d = PB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            out_q  <= '0;
        end else begin
            if (load) hold_q <= din;
            if (xfer)     out_q <= hold_q;
            else if (unf) out_q <= fmt16 ? MID16 : MID8;
        end
    end

    assign dout  = out_q;
    assign ready = (state_q == PB_EMPTY);

    p_midscale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == PB_EMPTY) |=> (dout == ($past(fmt16) ? MID16 : MID8)));
    p_play_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == PB_LOADED) |=> (ready && dout == $past(hold_q)));
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] base,
    input  logic             restart,
    input  logic             step,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q, cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign fire    = step && !restart && (cnt_inc == base);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (restart || fire)    cnt_q <= '0;
        else if (step)               cnt_q <= cnt_inc;
    end

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == '0));
endmodule

// File: rtl/smp_xfer_ctl.sv
module smp_xfer_ctl
    import smp_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              irq_clr,
    input  logic              legacy_mode,
    input  logic              fmt16,
    input  logic              smp_tick,
    input  logic [DATA_W-1:0] cap_in,
    input  logic [1:0]        rng_left,
    input  logic [1:0]        rng_right,
    input  logic              cap_pop,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_valid,
    input  logic              pb_push,
    input  logic [DATA_W-1:0] pb_in,
    output logic              pb_ready,
    output logic [DATA_W-1:0] pb_out,
    input  logic              pb_req,
    input  logic              cap_req,
    input  logic              cal_busy,
    output logic              err_sum,
    output logic              irq
);
    localparam int NBYTE = CNT_W / REG_W;   // bytes per base value (2)

    logic [REG_W-1:0] status_q;
    logic             pin_en_q;
    logic             pend_q;
    logic [CNT_W-1:0] base_q [NDIR];
    logic [CNT_W-1:0] base_sel [NDIR];
    logic [NDIR-1:0]  step, fire, base_wr, restart;
    logic             cap_ovr, pb_unf;

    pb_slot #(.DATA_W(DATA_W)) u_pb (
        .clk(clk), .rst_n(rst_n), .tick(smp_tick), .push(pb_push), .din(pb_in),
        .fmt16(fmt16), .dout(pb_out), .ready(pb_ready), .xfer(step[0]), .unf(pb_unf)
    );

    cap_slot #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .tick(smp_tick), .pop(cap_pop), .din(cap_in),
        .dout(cap_data), .valid(cap_valid), .xfer(step[1]), .ovr(cap_ovr)
    );

    // Base registers: upper byte at A_BASE + NBYTE*d, lower byte one above.
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam logic [2:0] A_HI = A_BASE + 3'(NBYTE * d);
        localparam logic [2:0] A_LO = A_HI + 3'd1;

        assign base_wr[d] = reg_wr && (reg_addr == A_HI || reg_addr == A_LO);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) base_q[d] <= '0;
            else if (reg_wr && reg_addr == A_HI) base_q[d][CNT_W-1:REG_W] <= reg_wdata;
            else if (reg_wr && reg_addr == A_LO) base_q[d][REG_W-1:0]     <= reg_wdata;
        end

        if (d == 0) begin : g_pb_base
            assign base_sel[d] = base_q[d];
            assign restart[d]  = base_wr[d];
        end else begin : g_cap_base
            assign base_sel[d] = legacy_mode ? base_q[0] : base_q[d];
            assign restart[d]  = base_wr[d] || (legacy_mode && base_wr[0]);
        end

        xfer_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .base(base_sel[d]), .restart(restart[d]),
            .step(step[d]), .fire(fire[d])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_en_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_PIN) pin_en_q <= reg_wdata[PIN_EN_BIT];
            pend_q <= (pend_q && !irq_clr) || (|fire);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q[ST_CAL] <= !cal_busy;
            status_q[ST_REQ] <= pb_req || cap_req;
            if (smp_tick) begin
                status_q[ST_OVR] <= cap_ovr;
                status_q[ST_UNF] <= pb_unf;
                status_q[3:2]    <= rng_right;
                status_q[1:0]    <= rng_left;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_PIN:   reg_rdata[PIN_EN_BIT] = pin_en_q;
            A_ERR:   reg_rdata = status_q;
            3'd2:    reg_rdata = base_q[0][CNT_W-1:REG_W];
            3'd3:    reg_rdata = base_q[0][REG_W-1:0];
            3'd4:    reg_rdata = base_q[1][CNT_W-1:REG_W];
            3'd5:    reg_rdata = base_q[1][REG_W-1:0];
            default: reg_rdata = '0;
        endcase
    end

    assign err_sum = status_q[ST_OVR] | status_q[ST_UNF];
    assign irq     = pend_q & pin_en_q;

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !irq_clr) |=> pend_q);
    p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && fire == '0) |=> !pend_q);
    p_ovr_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_tick && cap_valid && !cap_pop) |=> status_q[ST_OVR]);
    p_unf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_tick && pb_ready) |=> (status_q[ST_UNF] && err_sum));
endmodule

// File: tb/smp_xfer_ctl_tb_top.sv
`timescale 1ns/1ps
module smp_xfer_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_clr = 1'b0, legacy_mode = 1'b0, fmt16 = 1'b1, smp_tick = 1'b0;
    logic [15:0] cap_in = '0, pb_in = '0;
    logic [1:0]  rng_left = '0, rng_right = '0;
    logic        cap_pop = 1'b0, pb_push = 1'b0;
    logic [15:0] cap_data, pb_out;
    logic        cap_valid, pb_ready, err_sum, irq;
    logic        pb_req = 1'b0, cap_req = 1'b0, cal_busy = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smp_xfer_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_clr(irq_clr),
        .legacy_mode(legacy_mode), .fmt16(fmt16), .smp_tick(smp_tick),
        .cap_in(cap_in), .rng_left(rng_left), .rng_right(rng_right),
        .cap_pop(cap_pop), .cap_data(cap_data), .cap_valid(cap_valid),
        .pb_push(pb_push), .pb_in(pb_in), .pb_ready(pb_ready), .pb_out(pb_out),
        .pb_req(pb_req), .cap_req(cap_req), .cal_busy(cal_busy),
        .err_sum(err_sum), .irq(irq)
    );

    typedef struct packed {
        logic        push;
        logic [15:0] pdata;
        logic        pop;
        logic [15:0] cin;
        logic        f16;
        logic [1:0]  rl;
        logic [1:0]  rr;
        logic [15:0] e_out;
        logic [15:0] e_cap;
        logic [1:0]  e_err;   // {bit7, bit6}
        logic [3:0]  e_rng;   // status[3:0]
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'h1111, 1'b0, 16'hA001, 1'b1, 2'd1, 2'd2, 16'h1111, 16'hA001, 2'b00, 4'b1001},
        '{1'b0, 16'h0000, 1'b0, 16'hA002, 1'b1, 2'd3, 2'd0, 16'h0000, 16'hA001, 2'b11, 4'b0011},
        '{1'b1, 16'h2222, 1'b1, 16'hA003, 1'b0, 2'd0, 2'd3, 16'h2222, 16'hA003, 2'b00, 4'b1100},
        '{1'b0, 16'h0000, 1'b0, 16'hA004, 1'b0, 2'd2, 2'd2, 16'h0080, 16'hA003, 2'b11, 4'b1010},
        '{1'b1, 16'h3333, 1'b1, 16'hA005, 1'b0, 2'd1, 2'd1, 16'h3333, 16'hA005, 2'b00, 4'b0101},
        '{1'b0, 16'h0000, 1'b1, 16'hA006, 1'b1, 2'd0, 2'd0, 16'h0000, 16'hA006, 2'b01, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        pb_push = 1'b1; pb_in = v;
        @(negedge clk);
        pb_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        cap_pop = 1'b1;
        @(negedge clk);
        cap_pop = 1'b0;
    endtask

    task automatic tick(input logic [15:0] c);
        @(negedge clk);
        smp_tick = 1'b1; cap_in = c;
        @(negedge clk);
        smp_tick = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        // R1: reset state while reset is held
        repeat (3) @(posedge clk);
        for (int a = 0; a < 6; a++) begin
            reg_addr = 3'(a);
            #1 chk("R1 reg", {24'h0, reg_rdata}, 32'h0);
        end
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 cap_valid", {31'h0, cap_valid}, 32'h0);
        chk("R1 pb_ready", {31'h0, pb_ready}, 32'h1);
        chk("R1 err_sum", {31'h0, err_sum}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].push) push(TBL[i].pdata);
            if (TBL[i].pop)  pop();
            fmt16 = TBL[i].f16; rng_left = TBL[i].rl; rng_right = TBL[i].rr;
            tick(TBL[i].cin);
            chk("R4 pb_out", {16'h0, pb_out}, {16'h0, TBL[i].e_out});
            chk("R2/R3 cap_data", {16'h0, cap_data}, {16'h0, TBL[i].e_cap});
            rd(3'd1, v);
            chk("R3/R4 err bits", {30'h0, v[7:6]}, {30'h0, TBL[i].e_err});
            chk("R6 range", {28'h0, v[3:0]}, {28'h0, TBL[i].e_rng});
            chk("R5 err_sum", {31'h0, err_sum}, {31'h0, |TBL[i].e_err});
        end
        chk("R2 cap_valid", {31'h0, cap_valid}, 32'h1);

        // R7: live bits and read-only register
        cal_busy = 1'b1; pb_req = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd1, v);
        chk("R7 cal/req busy", {30'h0, v[5:4]}, 32'h1);
        cal_busy = 1'b0; pb_req = 1'b0; cap_req = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd1, v);
        chk("R7 cal/req idle", {30'h0, v[5:4]}, 32'h3);
        cap_req = 1'b0;
        wr(3'd1, 8'h00);
        rd(3'd1, v);
        chk("R7 write ignored", {30'h0, v[7:6]}, 32'h1);

        // R8: base register readback
        wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56); wr(3'd5, 8'h78);
        rd(3'd2, v); chk("R8 pb hi", {24'h0, v}, 32'h12);
        rd(3'd3, v); chk("R8 pb lo", {24'h0, v}, 32'h34);
        rd(3'd4, v); chk("R8 cap hi", {24'h0, v}, 32'h56);
        rd(3'd5, v); chk("R8 cap lo", {24'h0, v}, 32'h78);

        // R9: interrupt after base transfers (capture slot stays full, no capture transfers)
        wr(3'd2, 8'h00); wr(3'd3, 8'h03); wr(3'd4, 8'h00); wr(3'd5, 8'h02);
        wr(3'd0, 8'hFF);
        rd(3'd0, v); chk("R9 pin reg", {24'h0, v}, 32'h02);
        pulse_clr();
        for (int k = 0; k < 2; k++) begin push(16'h0100); tick(16'hB000); end
        chk("R9 before count", {31'h0, irq}, 32'h0);
        push(16'h0100); tick(16'hB000);
        chk("R9 at count", {31'h0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        chk("R9 held", {31'h0, irq}, 32'h1);
        pulse_clr();
        chk("R9 cleared", {31'h0, irq}, 32'h0);

        // R10: reload after terminal count
        for (int k = 0; k < 2; k++) begin push(16'h0200); tick(16'hB000); end
        chk("R10 reload early", {31'h0, irq}, 32'h0);
        push(16'h0200); tick(16'hB000);
        chk("R10 reload fire", {31'h0, irq}, 32'h1);
        pulse_clr();

        // R9: pin gated by enable, request kept
        wr(3'd0, 8'h00);
        for (int k = 0; k < 3; k++) begin push(16'h0300); tick(16'hB000); end
        chk("R9 gated", {31'h0, irq}, 32'h0);
        wr(3'd0, 8'h02);
        chk("R9 pending shows", {31'h0, irq}, 32'h1);
        pulse_clr();

        // R10: base write restarts the counter
        for (int k = 0; k < 2; k++) begin push(16'h0400); tick(16'hB000); end
        wr(3'd3, 8'h03);
        for (int k = 0; k < 2; k++) begin push(16'h0400); tick(16'hB000); end
        chk("R10 restart early", {31'h0, irq}, 32'h0);
        push(16'h0400); tick(16'hB000);
        chk("R10 restart fire", {31'h0, irq}, 32'h1);
        pulse_clr();

        // R11: legacy mode, capture counts against playback base (3, not 2)
        legacy_mode = 1'b1;
        for (int k = 0; k < 2; k++) begin pop(); tick(16'hC000 + 16'(k)); end
        chk("R11 legacy early", {31'h0, irq}, 32'h0);
        pop(); tick(16'hC002);
        chk("R11 legacy fire", {31'h0, irq}, 32'h1);
        chk("R11 capture data", {16'h0, cap_data}, 32'hC002);
        legacy_mode = 1'b0;
        pulse_clr();

        // R12: push while loaded, pop while empty
        push(16'h4444); push(16'h5555);
        tick(16'hD000);
        chk("R12 push ignored", {16'h0, pb_out}, 32'h4444);
        pop();
        chk("R12 slot emptied", {31'h0, cap_valid}, 32'h0);
        pop();
        tick(16'hD111);
        chk("R12 pop ignored", {15'h0, cap_valid, cap_data}, 32'h1D111);
        rd(3'd1, v);
        chk("R12 no overrun", {31'h0, v[7]}, 32'h0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule